// File: doc/BRIEF.md
# DMA Channel Register File with Aliased Trigger Windows

This block is the programming front end of one DMA channel. It keeps three working registers: a source pointer, a destination pointer and a transfer counter. A small configuration register selects the transfer width. The counter has two parts. One is a stored reload length. The other is a live countdown that the datapath consumes. Software reaches these registers through a plain register port made of an address, a write enable, write data and combinational read data.

The same registers appear in four 16-byte windows, and each window lists them in a different order. The last word of every window is a launch slot. A nonzero write there stores the value into whichever register sits in that slot, copies the length into the live counter and starts the channel. Software can therefore update the single field that changes between runs and launch with one write. A separate read-only word returns the reload length.

The datapath reports each completed read and each completed write with a one-cycle strobe. A read strobe moves the source pointer forward by the transfer width. A write strobe moves the destination pointer forward and uses up one transfer. The channel goes idle after the final write.

Top module: `dma_chan_regs`

## Requirements
- R1: After synchronous reset, both pointers, the reload length, the live count and the width field are zero, and `busy` and `start_pulse` are low.
- R2: Byte offsets map as follows, with each slot given as (word0, word1, word2, word3). 0x00 window: (src, dst, count, width). 0x10 window: (width, src, dst, count). 0x20 window: (width, count, src, dst). 0x30 window: (width, dst, count, src). Reads of a count slot return the live count. Reads of a width slot return the 2-bit width code, zero-extended.
- R3: A write to a count slot that is not a launch (word 0 to 2) changes only the reload length. The live count and `busy` keep their values, and offset 0x40 reads back the reload length.
- R4: A nonzero write to word 3 of any window stores the value in that slot's register and loads the live count from the reload length. If that length is nonzero, `busy` rises and `start_pulse` is high for exactly the cycle that follows the write.
- R5: When the launch slot is the count (offset 0x1C), the written value becomes the live count and the reload length at the same time.
- R6: A zero written to word 3 of a window updates that slot's register only. It launches nothing, does not raise `start_pulse`, and leaves the live count unchanged.
- R7: Width code 0 means 1 byte, code 1 means 2 bytes, and codes 2 and 3 mean 4 bytes. While `busy` is high, `rd_done` adds the width to the source pointer. While `busy` is high, `wr_done` adds the width to the destination pointer and lowers the live count by one.
- R8: `busy` falls on the `wr_done` that takes the live count to zero. Strobes that arrive while idle change no pointer and no count.
- R9: The reload length survives each run, so every new launch repeats the most recently programmed length.
- R10: A launch that loads a zero length leaves `busy` and `start_pulse` low, while still storing the launched value.
- R11: If a bus write to a pointer and that pointer's completion strobe arrive in the same cycle, the bus write wins.
- R12: Offset 0x40 is read-only, so writes to it are ignored. Every other offset, and any offset that is not a multiple of 4, reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Byte offset of the register access |
| bus_we | input | 1 | Write enable for this cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| rd_done | input | 1 | One read transfer completed |
| wr_done | input | 1 | One write transfer completed |
| start_pulse | output | 1 | High for one cycle when a launch starts the channel |
| busy | output | 1 | Channel has transfers remaining |
| cur_rd_addr | output | DATA_W | Current source pointer |
| cur_wr_addr | output | DATA_W | Current destination pointer |
| width_code | output | 2 | Transfer width code |

## Verification
The bench builds the block with the default `DATA_W` of 32, so it can use full-width pointer values and carry across the upper bits. It also exercises a count of zero, a count of one and small counts, so a run can end within a few cycles and the final-write edge is hit often. All four launch slots, all three width codes and same-cycle collisions of a write and a strobe are reached. Random accesses cover the 17 mapped offsets, several unmapped and unaligned ones, and data that is zero about a quarter of the time.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int OFFS_W = 7;
    localparam int WID_W  = 2;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_SRC  = 3'd1,
        SEL_DST  = 3'd2,
        SEL_CNT  = 3'd3,
        SEL_WID  = 3'd4,
        SEL_DBG  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     launch_slot;
    } slot_t;

    // Map a byte offset to the register it selects and whether it is a launch slot
    function automatic slot_t decode_offset(input logic [OFFS_W-1:0] offs);
        slot_t d;
        d.sel         = SEL_NONE;
        d.launch_slot = 1'b0;
        if (offs[1:0] == 2'b00) begin
            if (offs[6]) begin
                if (offs[5:2] == 4'd0) d.sel = SEL_DBG;
            end else begin
                d.launch_slot = (offs[3:2] == 2'd3);
                case (offs[5:2])
                    4'h0: d.sel = SEL_SRC;
                    4'h1: d.sel = SEL_DST;
                    4'h2: d.sel = SEL_CNT;
                    4'h3: d.sel = SEL_WID;
                    4'h4: d.sel = SEL_WID;
                    4'h5: d.sel = SEL_SRC;
                    4'h6: d.sel = SEL_DST;
                    4'h7: d.sel = SEL_CNT;
                    4'h8: d.sel = SEL_WID;
                    4'h9: d.sel = SEL_CNT;
                    4'hA: d.sel = SEL_SRC;
                    4'hB: d.sel = SEL_DST;
                    4'hC: d.sel = SEL_WID;
                    4'hD: d.sel = SEL_DST;
                    4'hE: d.sel = SEL_CNT;
                    default: d.sel = SEL_SRC;
                endcase
            end
        end
        return d;
    endfunction

    // Bytes moved per transfer for a width code
    function automatic logic [3:0] width_bytes(input logic [WID_W-1:0] code);
        case (code)
            2'd0:    return 4'd1;
            2'd1:    return 4'd2;
            default: return 4'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_ptr.sv
module dma_addr_ptr #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              advance,
    input  logic [DATA_W-1:0] step,
    output logic [DATA_W-1:0] ptr
);
    // Software write takes priority over a completion step
    always_ff @(posedge clk) begin
        if (rst)          ptr <= '0;
        else if (load)    ptr <= load_val;
        else if (advance) ptr <= ptr + step;
    end
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_reload,
    input  logic              launch,
    input  logic              launch_is_cnt,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_done,
    output logic [DATA_W-1:0] reload,
    output logic [DATA_W-1:0] live,
    output logic              busy,
    output logic              start_pulse
);
    logic [DATA_W-1:0] load_len;
    logic              load_nz;

    // A count-slot launch uses the fresh value; other launches use the stored length
    always_comb begin
        load_len = launch_is_cnt ? wdata : reload;
        load_nz  = (load_len != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload      <= '0;
            live        <= '0;
            busy        <= 1'b0;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= 1'b0;
            if (set_reload) reload <= wdata;
            if (launch) begin
                live        <= load_len;
                busy        <= load_nz;
                start_pulse <= load_nz;
            end else if (busy && wr_done) begin
                live <= live - 1'b1;
                if (live == {{(DATA_W-1){1'b0}}, 1'b1}) busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [OFFS_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 rd_done,
    input  logic                 wr_done,
    output logic                 start_pulse,
    output logic                 busy,
    output logic [DATA_W-1:0]    cur_rd_addr,
    output logic [DATA_W-1:0]    cur_wr_addr,
    output logic [WID_W-1:0]     width_code
);
    localparam int NUM_PTR = 2;
    localparam int PTR_SRC = 0;
    localparam int PTR_DST = 1;

    slot_t             dec;
    logic              launch;
    logic [DATA_W-1:0] step_w;
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] live_q;
    logic [WID_W-1:0]  wid_q;
    logic [NUM_PTR-1:0] ptr_ld;
    logic [NUM_PTR-1:0] ptr_adv;
    logic [DATA_W-1:0] ptr_q [NUM_PTR];

    always_comb begin
        dec    = decode_offset(bus_addr);
        launch = bus_we && dec.launch_slot && (bus_wdata != '0);
        step_w = {{(DATA_W-4){1'b0}}, width_bytes(wid_q)};
        ptr_ld[PTR_SRC]  = bus_we && (dec.sel == SEL_SRC);
        ptr_ld[PTR_DST]  = bus_we && (dec.sel == SEL_DST);
        ptr_adv[PTR_SRC] = busy && rd_done;
        ptr_adv[PTR_DST] = busy && wr_done;
    end

    always_ff @(posedge clk) begin
        if (rst)                                   wid_q <= '0;
        else if (bus_we && (dec.sel == SEL_WID))   wid_q <= bus_wdata[WID_W-1:0];
    end

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        dma_addr_ptr #(.DATA_W(DATA_W)) u_ptr (
            .clk      (clk),
            .rst      (rst),
            .load     (ptr_ld[g]),
            .load_val (bus_wdata),
            .advance  (ptr_adv[g]),
            .step     (step_w),
            .ptr      (ptr_q[g])
        );
    end

    dma_xfer_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk           (clk),
        .rst           (rst),
        .set_reload    (bus_we && (dec.sel == SEL_CNT)),
        .launch        (launch),
        .launch_is_cnt (dec.sel == SEL_CNT),
        .wdata         (bus_wdata),
        .wr_done       (wr_done),
        .reload        (reload_q),
        .live          (live_q),
        .busy          (busy),
        .start_pulse   (start_pulse)
    );

    always_comb begin
        case (dec.sel)
            SEL_SRC: bus_rdata = ptr_q[PTR_SRC];
            SEL_DST: bus_rdata = ptr_q[PTR_DST];
            SEL_CNT: bus_rdata = live_q;
            SEL_WID: bus_rdata = {{(DATA_W-WID_W){1'b0}}, wid_q};
            SEL_DBG: bus_rdata = reload_q;
            default: bus_rdata = '0;
        endcase
    end

    assign cur_rd_addr = ptr_q[PTR_SRC];
    assign cur_wr_addr = ptr_q[PTR_DST];
    assign width_code  = wid_q;

endmodule

// File: rtl/dma_chan_regs_sva.sv
module dma_chan_regs_sva
    import dma_chan_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              rd_done,
    input logic              wr_done,
    input logic              start_pulse,
    input logic              busy,
    input logic [DATA_W-1:0] cur_rd_addr,
    input logic [DATA_W-1:0] cur_wr_addr,
    input logic [WID_W-1:0]  width_code
);
    // R1
    a_r1_idle_after_reset: assert property (@(posedge clk)
        rst |=> (!busy && !start_pulse));

    // R4
    a_r4_start_with_busy: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> busy);

    // R6: a start needs a nonzero bus write in the cycle before
    a_r6_start_needs_write: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && start_pulse) |-> ($past(bus_we) && ($past(bus_wdata) != '0)));

    // R7
    a_r7_src_step: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_done && !bus_we) |=>
        (cur_rd_addr == $past(cur_rd_addr) + {{(DATA_W-4){1'b0}}, width_bytes($past(width_code))}));

    // R8: idle strobes leave the pointers alone
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !bus_we) |=> ($stable(cur_rd_addr) && $stable(cur_wr_addr)));

    // R8: busy only drops on a write completion or a bus write
    a_r8_busy_fall: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(busy)) |-> ($past(wr_done) || $past(bus_we)));
endmodule

bind dma_chan_regs dma_chan_regs_sva #(.DATA_W(DATA_W)) u_sva (
    .clk         (clk),
    .rst         (rst),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .rd_done     (rd_done),
    .wr_done     (wr_done),
    .start_pulse (start_pulse),
    .busy        (busy),
    .cur_rd_addr (cur_rd_addr),
    .cur_wr_addr (cur_wr_addr),
    .width_code  (width_code)
);

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [6:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          rd_done = 1'b0;
    logic          wr_done = 1'b0;
    logic          start_pulse, busy;
    logic [DW-1:0] cur_rd_addr, cur_wr_addr;
    logic [1:0]    width_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // reference state
    logic [DW-1:0] m_src, m_dst, m_rel, m_live;
    logic [1:0]    m_wid;
    logic          m_busy, m_start;
    logic [DW-1:0] last_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_regs #(.DATA_W(DW)) u_dma_chan_regs (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_done(rd_done),
        .wr_done(wr_done), .start_pulse(start_pulse), .busy(busy),
        .cur_rd_addr(cur_rd_addr), .cur_wr_addr(cur_wr_addr), .width_code(width_code)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // 0 none, 1 src, 2 dst, 3 count, 4 width, 5 reload view
    function automatic int map_sel(input logic [6:0] a);
        if (a[1:0] != 2'b00) return 0;
        if (a == 7'h40) return 5;
        if (a[6]) return 0;
        case (a[5:4])
            2'd0: case (a[3:2]) 2'd0: return 1; 2'd1: return 2; 2'd2: return 3; default: return 4; endcase
            2'd1: case (a[3:2]) 2'd0: return 4; 2'd1: return 1; 2'd2: return 2; default: return 3; endcase
            2'd2: case (a[3:2]) 2'd0: return 4; 2'd1: return 3; 2'd2: return 1; default: return 2; endcase
            default: case (a[3:2]) 2'd0: return 4; 2'd1: return 2; 2'd2: return 3; default: return 1; endcase
        endcase
    endfunction

    function automatic logic [DW-1:0] bytes_of(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [DW-1:0] model_read(input logic [6:0] a);
        case (map_sel(a))
            1: return m_src;
            2: return m_dst;
            3: return m_live;
            4: return {30'd0, m_wid};
            5: return m_rel;
            default: return '0;
        endcase
    endfunction

    task automatic model_reset();
        m_src = '0; m_dst = '0; m_rel = '0; m_live = '0;
        m_wid = '0; m_busy = 0; m_start = 0;
    endtask

    task automatic model_step(input logic we, input logic [6:0] a, input logic [DW-1:0] d,
                              input logic rd, input logic wr);
        int s;
        logic launch;
        logic [DW-1:0] len, step, n_src, n_dst;
        s      = we ? map_sel(a) : 0;
        launch = we && (s >= 1 && s <= 4) && (a[3:2] == 2'd3) && (d != 0);
        step   = bytes_of(m_wid);
        n_src  = (s == 1) ? d : (m_busy && rd) ? m_src + step : m_src;
        n_dst  = (s == 2) ? d : (m_busy && wr) ? m_dst + step : m_dst;
        m_start = 0;
        if (launch) begin
            len = (s == 3) ? d : m_rel;
            m_live = len; m_busy = (len != 0); m_start = (len != 0);
        end else if (m_busy && wr) begin
            m_live = m_live - 1;
            if (m_live == 0) m_busy = 0;
        end
        if (s == 3) m_rel = d;
        if (s == 4) m_wid = d[1:0];
        m_src = n_src; m_dst = n_dst;
    endtask

    // One cycle: drive at negedge, sample read data, then outputs after the edge
    task automatic cyc(input logic we, input logic [6:0] a, input logic [DW-1:0] d,
                       input logic rd, input logic wr);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; rd_done = rd; wr_done = wr;
        #1;
        last_rdata = bus_rdata;
        chk("R2 R3 R12 read data", bus_rdata, model_read(a));
        model_step(we, a, d, rd, wr);
        @(posedge clk); #1;
        bus_we = 0; rd_done = 0; wr_done = 0;
        chk("R7 R11 src pointer", cur_rd_addr, m_src);
        chk("R7 R11 dst pointer", cur_wr_addr, m_dst);
        chk("R4 R8 busy", {31'd0, busy}, {31'd0, m_busy});
        chk("R4 R6 start_pulse", {31'd0, start_pulse}, {31'd0, m_start});
    endtask

    task automatic rd_reg(input logic [6:0] a);
        cyc(0, a, '0, 0, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 0);
        chk("R1 src", cur_rd_addr, 0);
        rd_reg(7'h08); chk("R1 count", last_rdata, 0);
        rd_reg(7'h40); chk("R1 reload", last_rdata, 0);

        // setup, R3 plain count write
        cyc(1, 7'h10, 32'd2, 0, 0);          // width 4 bytes
        cyc(1, 7'h00, 32'h0000_0100, 0, 0);
        cyc(1, 7'h04, 32'h0000_0200, 0, 0);
        cyc(1, 7'h08, 32'd3, 0, 0);
        chk("R3 no busy after count write", {31'd0, busy}, 0);
        rd_reg(7'h08); chk("R3 live untouched", last_rdata, 0);
        rd_reg(7'h40); chk("R3 reload view", last_rdata, 3);

        // R2 layout
        rd_reg(7'h14); chk("R2 0x14 src", last_rdata, 32'h100);
        rd_reg(7'h18); chk("R2 0x18 dst", last_rdata, 32'h200);
        rd_reg(7'h28); chk("R2 0x28 src", last_rdata, 32'h100);
        rd_reg(7'h34); chk("R2 0x34 dst", last_rdata, 32'h200);
        rd_reg(7'h30); chk("R2 0x30 width", last_rdata, 2);

        // R4 launch through width slot
        cyc(1, 7'h0C, 32'd2, 0, 0);
        chk("R4 start pulse", {31'd0, start_pulse}, 1);
        chk("R4 busy", {31'd0, busy}, 1);
        rd_reg(7'h08); chk("R4 live loaded", last_rdata, 3);
        chk("R4 pulse one cycle", {31'd0, start_pulse}, 0);

        // R7 stepping
        cyc(0, 7'h00, '0, 1, 0); chk("R7 src +4", cur_rd_addr, 32'h104);
        cyc(0, 7'h00, '0, 0, 1); chk("R7 dst +4", cur_wr_addr, 32'h204);
        rd_reg(7'h08); chk("R7 live dec", last_rdata, 2);
        // R11 collision
        cyc(1, 7'h00, 32'h500, 1, 0); chk("R11 write wins", cur_rd_addr, 32'h500);
        // R8 finish
        cyc(0, 7'h00, '0, 0, 1); chk("R8 still busy", {31'd0, busy}, 1);
        cyc(0, 7'h00, '0, 0, 1); chk("R8 busy falls", {31'd0, busy}, 0);
        cyc(0, 7'h00, '0, 1, 1); chk("R8 idle src hold", cur_rd_addr, 32'h500);
        chk("R8 idle dst hold", cur_wr_addr, 32'h20C);

        // R9 relaunch repeats, with 2-byte width
        cyc(1, 7'h0C, 32'd1, 0, 0);
        rd_reg(7'h08); chk("R9 relaunch length", last_rdata, 3);
        cyc(0, 7'h00, '0, 0, 1); chk("R7 dst +2", cur_wr_addr, 32'h20E);

        // R5 count launch
        cyc(1, 7'h1C, 32'd5, 0, 0);
        rd_reg(7'h24); chk("R5 live", last_rdata, 5);
        rd_reg(7'h40); chk("R5 reload", last_rdata, 5);

        // R6 zero into launch slot
        cyc(1, 7'h2C, 32'd0, 0, 0);
        chk("R6 no pulse", {31'd0, start_pulse}, 0);
        chk("R6 dst stored", cur_wr_addr, 0);
        rd_reg(7'h08); chk("R6 live kept", last_rdata, 5);

        // R12 read-only view and holes
        cyc(1, 7'h40, 32'h77, 0, 0);
        rd_reg(7'h40); chk("R12 reload kept", last_rdata, 5);
        cyc(1, 7'h44, 32'h99, 0, 0);
        rd_reg(7'h44); chk("R12 hole", last_rdata, 0);
        rd_reg(7'h01); chk("R12 unaligned", last_rdata, 0);

        // R10 zero-length launch
        repeat (5) cyc(0, 7'h00, '0, 0, 1);
        cyc(1, 7'h08, 32'd0, 0, 0);
        cyc(1, 7'h3C, 32'h40, 0, 0);
        chk("R10 no busy", {31'd0, busy}, 0);
        chk("R10 no pulse", {31'd0, start_pulse}, 0);
        chk("R10 src stored", cur_rd_addr, 32'h40);

        // random traffic against the reference
        for (int i = 0; i < 1500; i++) begin
            logic [6:0]    a;
            logic [DW-1:0] d;
            int r;
            r = $urandom_range(0, 19);
            if (r < 16)       a = 7'(r * 4);
            else if (r == 16) a = 7'h40;
            else if (r == 17) a = 7'h48;
            else if (r == 18) a = 7'h06;
            else              a = 7'h7C;
            d = ($urandom_range(0, 3) == 0) ? '0
              : ($urandom_range(0, 1) == 1) ? DW'($urandom_range(1, 6)) : DW'($urandom);
            cyc($urandom_range(0, 3) == 0, a, d, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule